// File: doc/BRIEF.md
# Sticky Thermal Alert and Maximum Tracker

This block watches processed 16-bit signed temperature results that arrive one at a time from eight sensor slots: four sockets, each with two domains. Each socket owns one alert threshold that both of its domains share. When a new reading is strictly greater than its socket's threshold, the block sets a sticky, active-low alert line. It also remembers which slot caused that alert. The alert holds through later cooler readings and is released only by an explicit clear strobe.

The same block answers three queries from stored state:
- The largest valid temperature among the enabled slots.
- The slot that held that maximum when the maximum was last queried.
- The slot that raised the current alert.

Any 16-bit value from 8000h to 81FFh is an error code. Error codes are never compared against a threshold and never take part in the maximum search. A query that has no meaningful answer returns a fixed error word.

Top module: `thermal_watch`

## Requirements
- R1: A reading whose value lies in 8000h..81FFh (an error code) never sets the alert and is never chosen as the maximum.
- R2: Slot s belongs to socket s/2, so slots 2k and 2k+1 compare against threshold k. Thresholds reset to 7FFFh and are written through `thr_we`, `thr_sock` and `thr_value`. The compare is a signed strictly-greater-than.
- R3: `alert_n` is 1 after reset. In the cycle after a qualifying reading, `alert_n` goes to 0. It then stays 0, whatever later readings arrive, until `clear_alert` is pulsed.
- R4: A clear releases `alert_n` in the cycle after the strobe. The clear does not re-evaluate stored values. The alert asserts again only on the next new reading that exceeds its threshold.
- R5: While `mask_alerts` is 1, no new alert is set. An alert that is already active stays active.
- R6: An alert query returns `{8'h00, slot}`, where slot is the first violating slot since the last clear; later violations do not overwrite it. With no active alert, the alert query returns 8104h.
- R7: A maximum query returns the largest signed non-error stored value among the slots whose `slot_enable` bit is 1. On a tie, the lowest slot index wins. The query returns 8103h when no enabled slot holds a valid value. A slot that has not been written since reset holds 8102h, which is an error code.
- R8: A location query returns `{8'h00, slot}` for the slot captured by the most recent maximum query. It returns 8103h if no maximum query has happened since reset, or if the last one returned 8103h.
- R9: The answer to a query appears on `q_data`, with `q_valid` high, in the cycle after the strobe. When strobes coincide, a maximum query beats a location query, which beats an alert query. A clear in the same cycle as a violating reading leaves the alert released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | New processed reading strobe |
| res_slot | input | 3 | Slot index of the reading (socket*2 + domain) |
| res_value | input | 16 | Signed reading or error code |
| slot_enable | input | 8 | Per-slot enable for the maximum search |
| mask_alerts | input | 1 | Blocks new alerts when 1 |
| thr_we | input | 1 | Threshold write strobe |
| thr_sock | input | 2 | Socket whose threshold is written |
| thr_value | input | 16 | Threshold value |
| clear_alert | input | 1 | Releases the active alert |
| max_query | input | 1 | Maximum temperature query strobe |
| loc_query | input | 1 | Maximum location query strobe |
| alert_query | input | 1 | Alert slot query strobe |
| alert_n | output | 1 | Active-low sticky alert |
| q_valid | output | 1 | Query answer valid |
| q_data | output | 16 | Query answer |

## Verification
A wrong alert latch or a wrong threshold index shows up on `alert_n` one cycle after the offending reading. An overwritten first-violation slot shows up on the next alert query. A stored value that is corrupted or wrongly classified, including a slot that keeps a stale value, stays hidden until a maximum query covers that slot with the matching enable pattern. For that reason, every enable pattern is queried against a known set of slot contents. A broken location capture is visible only in the location query that follows a maximum query, so each maximum query is paired with a location query.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int TW_W = 16;

  localparam logic [TW_W-1:0] TW_ERR_UNPOLLED = 16'h8102;
  localparam logic [TW_W-1:0] TW_ERR_NO_MAX   = 16'h8103;
  localparam logic [TW_W-1:0] TW_ERR_NO_ALERT = 16'h8104;
  localparam logic [TW_W-1:0] TW_THR_RESET    = 16'h7FFF;

  // error codes occupy 8000h..81FFh: top seven bits equal 1000000b
  function automatic logic is_err_code(input logic [TW_W-1:0] v);
    return v[TW_W-1:9] == 7'b1000000;
  endfunction

  function automatic logic signed_gt(input logic [TW_W-1:0] a,
                                     input logic [TW_W-1:0] b);
    return $signed(a) > $signed(b);
  endfunction

  function automatic logic exceeds_limit(input logic [TW_W-1:0] v,
                                         input logic [TW_W-1:0] lim);
    return !is_err_code(v) && signed_gt(v, lim);
  endfunction
endpackage

// File: rtl/tw_slot_store.sv
module tw_slot_store #(
  parameter int N_SLOT = 8,
  parameter int SW     = 16,
  localparam int SLW   = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SLW-1:0]        wr_slot,
  input  logic [SW-1:0]         wr_value,
  output logic [N_SLOT*SW-1:0]  vals_flat
);
  import tw_pkg::*;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic [SW-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        val_q <= TW_ERR_UNPOLLED;
      else if (wr_en && (wr_slot == SLW'(g)))
        val_q <= wr_value;
    end
    assign vals_flat[g*SW +: SW] = val_q;
  end
endmodule

// File: rtl/tw_max_scan.sv
module tw_max_scan #(
  parameter int N_SLOT = 8,
  parameter int SW     = 16,
  localparam int SLW   = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic [N_SLOT*SW-1:0] vals_flat,
  input  logic [N_SLOT-1:0]    enable,
  output logic                 found,
  output logic [SW-1:0]        max_val,
  output logic [SLW-1:0]       max_idx
);
  import tw_pkg::*;

  // candidate qualification per slot, visible as named wires
  logic [N_SLOT-1:0] cand;
  for (genvar g = 0; g < N_SLOT; g++) begin : g_cand
    assign cand[g] = enable[g] && !is_err_code(vals_flat[g*SW +: SW]);
  end

  // linear scan; strict greater keeps the lowest index on ties
  always_comb begin
    found   = 1'b0;
    max_val = '0;
    max_idx = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (cand[i] && (!found || signed_gt(vals_flat[i*SW +: SW], max_val))) begin
        found   = 1'b1;
        max_val = vals_flat[i*SW +: SW];
        max_idx = SLW'(i);
      end
    end
  end
endmodule

// File: rtl/tw_alert_latch.sv
module tw_alert_latch #(
  parameter int N_SOCK = 4,
  parameter int N_DOM  = 2,
  parameter int SW     = 16,
  localparam int N_SLOT = N_SOCK * N_DOM,
  localparam int SLW    = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int SKW    = (N_SOCK > 1) ? $clog2(N_SOCK) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_valid,
  input  logic [SLW-1:0] rd_slot,
  input  logic [SW-1:0]  rd_value,
  input  logic           mask_new,
  input  logic           clear,
  input  logic           thr_we,
  input  logic [SKW-1:0] thr_sel,
  input  logic [SW-1:0]  thr_din,
  output logic           over_evt,
  output logic           set_evt,
  output logic           alert_active,
  output logic [SLW-1:0] alert_slot
);
  import tw_pkg::*;

  logic [SW-1:0]  thr_q [N_SOCK];
  logic [SKW-1:0] sock_idx;

  for (genvar g = 0; g < N_SOCK; g++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n)
        thr_q[g] <= TW_THR_RESET;
      else if (thr_we && (thr_sel == SKW'(g)))
        thr_q[g] <= thr_din;
    end
  end

  assign sock_idx = SKW'(rd_slot / SLW'(N_DOM));
  assign over_evt = rd_valid && exceeds_limit(rd_value, thr_q[sock_idx]);
  assign set_evt  = over_evt && !mask_new && !alert_active && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alert_active <= 1'b0;
      alert_slot   <= '0;
    end else if (clear) begin
      alert_active <= 1'b0;
    end else if (set_evt) begin
      alert_active <= 1'b1;
      alert_slot   <= rd_slot;
    end
  end
endmodule

// File: rtl/tw_query_port.sv
module tw_query_port #(
  parameter int N_SLOT = 8,
  parameter int SW     = 16,
  localparam int SLW   = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           max_q,
  input  logic           loc_q,
  input  logic           alrt_q,
  input  logic           found,
  input  logic [SW-1:0]  max_val,
  input  logic [SLW-1:0] max_idx,
  input  logic           alert_active,
  input  logic [SLW-1:0] alert_slot,
  output logic           q_valid,
  output logic [SW-1:0]  q_data
);
  import tw_pkg::*;

  logic           loc_ok;
  logic [SLW-1:0] loc_idx;
  logic [SW-1:0]  ans;

  always_comb begin
    if (max_q)
      ans = found ? max_val : TW_ERR_NO_MAX;
    else if (loc_q)
      ans = loc_ok ? SW'(loc_idx) : TW_ERR_NO_MAX;
    else
      ans = alert_active ? SW'(alert_slot) : TW_ERR_NO_ALERT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_ok  <= 1'b0;
      loc_idx <= '0;
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= max_q || loc_q || alrt_q;
      if (max_q || loc_q || alrt_q)
        q_data <= ans;
      if (max_q) begin
        loc_ok  <= found;
        loc_idx <= max_idx;
      end
    end
  end
endmodule

// File: rtl/thermal_watch.sv
module thermal_watch #(
  parameter int N_SOCK = 4,
  parameter int N_DOM  = 2,
  localparam int SW     = 16,
  localparam int N_SLOT = N_SOCK * N_DOM,
  localparam int SLW    = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int SKW    = (N_SOCK > 1) ? $clog2(N_SOCK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [SLW-1:0]    res_slot,
  input  logic [SW-1:0]     res_value,
  input  logic [N_SLOT-1:0] slot_enable,
  input  logic              mask_alerts,
  input  logic              thr_we,
  input  logic [SKW-1:0]    thr_sock,
  input  logic [SW-1:0]     thr_value,
  input  logic              clear_alert,
  input  logic              max_query,
  input  logic              loc_query,
  input  logic              alert_query,
  output logic              alert_n,
  output logic              q_valid,
  output logic [SW-1:0]     q_data
);
  logic [N_SLOT*SW-1:0] vals_flat;
  logic                 max_found;
  logic [SW-1:0]        max_val;
  logic [SLW-1:0]       max_idx;
  logic                 over_evt;
  logic                 set_evt;
  logic                 alert_active;
  logic [SLW-1:0]       alert_slot;

  tw_slot_store #(.N_SLOT(N_SLOT), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(res_valid), .wr_slot(res_slot), .wr_value(res_value),
    .vals_flat(vals_flat)
  );

  tw_max_scan #(.N_SLOT(N_SLOT), .SW(SW)) u_scan (
    .vals_flat(vals_flat), .enable(slot_enable),
    .found(max_found), .max_val(max_val), .max_idx(max_idx)
  );

  tw_alert_latch #(.N_SOCK(N_SOCK), .N_DOM(N_DOM), .SW(SW)) u_alert (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(res_valid), .rd_slot(res_slot), .rd_value(res_value),
    .mask_new(mask_alerts), .clear(clear_alert),
    .thr_we(thr_we), .thr_sel(thr_sock), .thr_din(thr_value),
    .over_evt(over_evt), .set_evt(set_evt),
    .alert_active(alert_active), .alert_slot(alert_slot)
  );

  tw_query_port #(.N_SLOT(N_SLOT), .SW(SW)) u_query (
    .clk(clk), .rst_n(rst_n),
    .max_q(max_query), .loc_q(loc_query), .alrt_q(alert_query),
    .found(max_found), .max_val(max_val), .max_idx(max_idx),
    .alert_active(alert_active), .alert_slot(alert_slot),
    .q_valid(q_valid), .q_data(q_data)
  );

  assign alert_n = !alert_active;
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int SLW = 3,
  parameter int SW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           res_valid,
  input logic [SW-1:0]  res_value,
  input logic           mask_alerts,
  input logic           clear_alert,
  input logic           max_query,
  input logic           loc_query,
  input logic           alert_query,
  input logic           alert_n,
  input logic           q_valid,
  input logic [SLW-1:0] alert_slot,
  input logic           over_evt,
  input logic           set_evt
);
  import tw_pkg::*;

  // R1: an error-coded reading cannot raise the alert
  p_err_no_alert_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && is_err_code(res_value) && alert_n |=> alert_n);

  // R3: an active alert holds until a clear arrives
  p_alert_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n && !clear_alert |=> !alert_n);

  // R4: a clear releases the line on the next cycle
  p_clear_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_alert |=> alert_n);

  // R5: masked cycles never create a new alert
  p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_alerts && alert_n |=> alert_n);

  // R6: the recorded slot is frozen while the alert is active
  p_first_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n && !clear_alert |=> $stable(alert_slot));

  // R3: an unmasked over-limit reading with the line idle raises it
  p_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    over_evt && !mask_alerts && !clear_alert && alert_n |=> !alert_n);

  // R9: a set event never coincides with a clear
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |-> !clear_alert);

  // R9: answer valid exactly one cycle after any query strobe
  p_qvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (max_query || loc_query || alert_query) |=> q_valid);
  p_qidle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(max_query || loc_query || alert_query) |=> !q_valid);
endmodule

bind thermal_watch tw_checker #(.SLW(SLW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
  .mask_alerts(mask_alerts), .clear_alert(clear_alert),
  .max_query(max_query), .loc_query(loc_query), .alert_query(alert_query),
  .alert_n(alert_n), .q_valid(q_valid), .alert_slot(alert_slot),
  .over_evt(over_evt), .set_evt(set_evt)
);

// File: tb/tb_thermal_watch.sv
`timescale 1ns/1ps
module tb_thermal_watch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_valid;
  logic [2:0]  res_slot;
  logic [15:0] res_value;
  logic [7:0]  slot_enable;
  logic        mask_alerts;
  logic        thr_we;
  logic [1:0]  thr_sock;
  logic [15:0] thr_value;
  logic        clear_alert;
  logic        max_query;
  logic        loc_query;
  logic        alert_query;
  logic        alert_n;
  logic        q_valid;
  logic [15:0] q_data;

  always #2.5 clk = ~clk;

  thermal_watch dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
    .res_value(res_value), .slot_enable(slot_enable), .mask_alerts(mask_alerts),
    .thr_we(thr_we), .thr_sock(thr_sock), .thr_value(thr_value),
    .clear_alert(clear_alert), .max_query(max_query), .loc_query(loc_query),
    .alert_query(alert_query), .alert_n(alert_n), .q_valid(q_valid), .q_data(q_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_val [8];
  logic [15:0] m_thr [4];
  bit          m_alert;
  int          m_aslot;
  bit          m_loc_ok;
  int          m_loc;

  function automatic bit ref_err(logic [15:0] v);
    return (v >= 16'h8000) && (v <= 16'h81FF);
  endfunction

  function automatic int sx(logic [15:0] v);
    return (v >= 16'h8000) ? int'(v) - 65536 : int'(v);
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    res_valid = 0; thr_we = 0; clear_alert = 0;
    max_query = 0; loc_query = 0; alert_query = 0;
  endtask

  task automatic set_thr(int s, logic [15:0] v);
    @(negedge clk); thr_we = 1; thr_sock = 2'(s); thr_value = v;
    @(negedge clk); idle();
    m_thr[s] = v;
  endtask

  task automatic read_in(int s, logic [15:0] v, bit clr);
    @(negedge clk);
    res_valid = 1; res_slot = 3'(s); res_value = v; clear_alert = clr;
    @(negedge clk); idle();
    if (clr) m_alert = 0;
    else if (!ref_err(v) && sx(v) > sx(m_thr[s/2]) && !mask_alerts && !m_alert) begin
      m_alert = 1; m_aslot = s;
    end
    m_val[s] = v;
  endtask

  task automatic do_clear();
    @(negedge clk); clear_alert = 1;
    @(negedge clk); idle();
    m_alert = 0;
  endtask

  function automatic logic [15:0] ref_max(output bit ok, output int idx);
    logic [15:0] best = 16'h8103;
    ok = 0; idx = 0;
    for (int i = 0; i < 8; i++)
      if (slot_enable[i] && !ref_err(m_val[i]) && (!ok || sx(m_val[i]) > sx(best))) begin
        ok = 1; best = m_val[i]; idx = i;
      end
    return best;
  endfunction

  task automatic q_max(string tag);
    bit ok; int idx; logic [15:0] e;
    e = ref_max(ok, idx);
    @(negedge clk); max_query = 1;
    @(negedge clk); idle();
    check(q_valid && q_data == e, tag, q_data, e);
    m_loc_ok = ok; m_loc = idx;
  endtask

  task automatic q_loc(string tag);
    logic [15:0] e;
    e = m_loc_ok ? 16'(m_loc) : 16'h8103;
    @(negedge clk); loc_query = 1;
    @(negedge clk); idle();
    check(q_valid && q_data == e, tag, q_data, e);
  endtask

  task automatic q_alert(string tag);
    logic [15:0] e;
    e = m_alert ? 16'(m_aslot) : 16'h8104;
    @(negedge clk); alert_query = 1;
    @(negedge clk); idle();
    check(q_valid && q_data == e, tag, q_data, e);
  endtask

  task automatic chk_line(string tag);
    check(alert_n == !m_alert, tag, 16'(alert_n), 16'(!m_alert));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] tv [4];
    logic [15:0] fix [8];
    idle();
    rst_n = 0; res_slot = 0; res_value = 0; slot_enable = 0;
    mask_alerts = 0; thr_sock = 0; thr_value = 0;
    for (int i = 0; i < 8; i++) m_val[i] = 16'h8102;
    for (int i = 0; i < 4; i++) m_thr[i] = 16'h7FFF;
    m_alert = 0; m_aslot = 0; m_loc_ok = 0; m_loc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk_line("R3 reset alert_n");
    check(!q_valid, "R9 reset q_valid", 16'(q_valid), 16'h0);
    q_loc("R8 loc before any max query");
    q_alert("R6 no alert at reset");
    slot_enable = 8'hFF;
    q_max("R7 unwritten slots are errors");
    q_loc("R8 loc after error max");

    // R2: reset threshold 7FFF cannot be exceeded
    read_in(3, 16'h7FFF, 0); chk_line("R2 reset threshold 7FFF");
    read_in(6, 16'h7FFE, 0); chk_line("R2 reset threshold 7FFE");

    // per-socket thresholds
    tv[0] = 16'h0640; tv[1] = 16'hFFC0; tv[2] = 16'h12C0; tv[3] = 16'h8200;
    for (int s = 0; s < 4; s++) set_thr(s, tv[s]);

    // sweep: every slot, boundary and error values, mask and clear patterns
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 24; k++) begin
        case (k)
          0: v = m_thr[s/2];
          1: v = m_thr[s/2] + 16'd1;
          2: v = m_thr[s/2] - 16'd1;
          3: v = 16'h8000;
          4: v = 16'h81FF;
          5: v = 16'h8100;
          6: v = 16'h8200;
          7: v = 16'h7FFF;
          8: v = 16'h0000;
          9: v = 16'hFFFF;
          10: v = 16'h80FF;
          11: v = m_thr[s/2] + 16'd2;
          default: v = 16'(k * 16'h1D3B) ^ 16'(s * 16'h0101);
        endcase
        mask_alerts = (k % 5 == 4);
        read_in(s, v, 0);
        chk_line($sformatf("R1 R2 R3 R5 slot%0d val=%h", s, v));
        q_alert($sformatf("R6 first slot after slot%0d val=%h", s, v));
        if (k % 3 == 2) begin
          do_clear();
          chk_line("R4 clear releases");
        end
      end
    end
    mask_alerts = 0;

    // R5: mask keeps an existing alert
    do_clear();
    read_in(4, 16'h2000, 0); chk_line("R5 setup alert");
    mask_alerts = 1;
    read_in(1, 16'h0000, 0); chk_line("R5 masked keeps active");
    q_alert("R6 slot kept under mask");
    do_clear(); chk_line("R5 cleared");
    read_in(4, 16'h2000, 0); chk_line("R5 masked blocks new");
    mask_alerts = 0;

    // R4: value still high after clear, reasserts only on next reading
    read_in(5, 16'h1400, 0); chk_line("R4 setup");
    do_clear(); chk_line("R4 stays released without reading");
    @(negedge clk); chk_line("R4 still released");
    read_in(5, 16'h1400, 0); chk_line("R4 reasserts on next reading");

    // R9: clear together with violation leaves alert released
    @(negedge clk); res_valid = 1; res_slot = 3'd7; res_value = 16'h0000; clear_alert = 1;
    @(negedge clk); idle(); m_alert = 0; m_val[7] = 16'h0000;
    chk_line("R9 clear wins over same-cycle violation");

    // R1/R7: known contents, all enable patterns
    fix[0] = 16'h0640; fix[1] = 16'h8100; fix[2] = 16'hFFC0; fix[3] = 16'h0640;
    fix[4] = 16'h81FF; fix[5] = 16'h7000; fix[6] = 16'h8000; fix[7] = 16'h12C0;
    mask_alerts = 1;
    for (int i = 0; i < 8; i++) read_in(i, fix[i], 0);
    mask_alerts = 0;
    for (int m = 0; m < 256; m++) begin
      slot_enable = 8'(m);
      q_max($sformatf("R7 R1 max enable=%02h", m));
      q_loc($sformatf("R8 loc enable=%02h", m));
    end

    // R9: priority max over alert, loc over alert
    slot_enable = 8'h01;
    @(negedge clk); max_query = 1; alert_query = 1;
    @(negedge clk); idle();
    check(q_valid && q_data == 16'h0640, "R9 max beats alert", q_data, 16'h0640);
    m_loc_ok = 1; m_loc = 0;
    @(negedge clk); loc_query = 1; alert_query = 1;
    @(negedge clk); idle();
    check(q_valid && q_data == 16'h0000, "R9 loc beats alert", q_data, 16'h0000);
    @(negedge clk);
    check(!q_valid, "R9 q_valid drops", 16'(q_valid), 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule